// File: doc/BRIEF.md
# Single-Cell Charge Sequencer

This block is the control core of a linear charger for one lithium cell. It receives digital comparator flags from the analog front end (input above battery, input above the lockout level, battery below the precharge threshold, battery below the recharge threshold, and charge current below the termination level). It also receives an active-low charge enable and a one-millisecond timebase tick. From these it decides which charge current source is on, and it reports progress on two status lines and a power-good line.

Each flag passes through a two-flop synchronizer. Every threshold crossing that must persist before the sequencer acts is filtered by a tick-counted deglitch. This covers a fall below the precharge threshold during fast charge, termination, recharge and loss of input. Two safety timers bound the precharge and fast-charge phases. After a timer fault the block recovers on its own. If the battery sits below the recharge threshold, a small sense current runs until the battery rises above it. Once the battery is above the threshold, a later fall below it starts a new cycle. All lengths are parameters counted in ticks, so a bench can shorten them.

Top module: `cell_charge_seq`

## Requirements
- R1: After reset the block is in sleep: all six outputs are low. Reset takes effect whatever the state.
- R2: With power valid and charge_en_n low, a cycle starts in precharge if batt_low is high, else in fast charge; each start clears the phase timer.
- R3: In precharge, batt_low going low moves the block to fast charge with no deglitch.
- R4: In fast charge, batt_low must stay high for DG_TICKS ticks before the block returns to precharge.
- R5: When the phase timer reaches PRE_TICKS ticks in precharge, or CHG_TICKS ticks in fast charge, both charge currents stop and the fault state is entered. The timer advances only on tick.
- R6: In fast charge, chg_term held high for DG_TICKS ticks ends the cycle in done, with both charge currents off.
- R7: In done, batt_below_rch held high for DG_TICKS ticks starts a new cycle.
- R8: In fault, fault_sense_en is high while batt_below_rch is high and stays low once it has gone low. With fault_sense_en low, batt_below_rch rising clears the fault and starts a new cycle.
- R9: Status lines (stat_a, stat_b): precharge (1,1); fast charge (1,0); done (0,1); fault, disabled or sleep (0,0). At most one of the three current enables is high.
- R10: charge_en_n high turns off all currents and clears any fault; the following high-to-low edge starts a new cycle with cleared timers.
- R11: in_above_batt held low for DG_TICKS ticks puts the block in sleep, releasing power_good; a return high leaves sleep at once.
- R12: in_above_uvlo low forces sleep with no deglitch, dropping every enable when the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle timebase pulse, nominally 1 ms |
| in_above_batt | input | 1 | Input supply above battery voltage (async) |
| in_above_uvlo | input | 1 | Input supply above lockout level (async) |
| batt_low | input | 1 | Battery below precharge threshold (async) |
| batt_below_rch | input | 1 | Battery below recharge threshold (async) |
| chg_term | input | 1 | Charge current below termination level (async) |
| charge_en_n | input | 1 | Active-low charge enable (async) |
| pre_en | output | 1 | Precharge current source on |
| fast_en | output | 1 | Fast-charge regulation on |
| fault_sense_en | output | 1 | Small fault-sense current on |
| stat_a | output | 1 | First status line, high means asserted |
| stat_b | output | 1 | Second status line, high means asserted |
| power_good | output | 1 | Input valid |

## Verification
The bench probes each deglitch just before and well after its window. A design that skipped a filter would leave fast charge, reach done or enter sleep too early. One that filtered the precharge exit or the lockout would still show the old state when the short check runs. Fault recovery is driven along both paths: a design that enabled the sense current on the wrong side of the recharge threshold, or restarted without waiting for the rise, would show the wrong status or enables. With the tick held low, the sequencer must stay in precharge indefinitely, which catches timers clocked by the system clock. Toggling the charge enable from a fault must restart charging.

// File: rtl/chg_pkg.sv
package chg_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_OFF   = 3'd1,
        ST_PRE   = 3'd2,
        ST_FAST  = 3'd3,
        ST_DONE  = 3'd4,
        ST_FAULT = 3'd5
    } chg_state_e;

    // filter slots
    localparam int FLT_SLEEP = 0;
    localparam int FLT_LOWV  = 1;
    localparam int FLT_TERM  = 2;
    localparam int FLT_RCH   = 3;
    localparam int NUM_FLT   = 4;

endpackage

// File: rtl/chg_sync.sv
module chg_sync #(
    parameter int            W    = 6,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q_s
);
    typedef struct packed {
        logic [W-1:0] m;
        logic [W-1:0] s;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d.m = d_a;
        nxt_d.s = cur_q.m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{m: INIT, s: INIT};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign q_s = cur_q.s;
endmodule

// File: rtl/chg_dglitch.sv
module chg_dglitch #(
    parameter int DG_TICKS = 375
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic held
);
    localparam int CW = $clog2(DG_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(DG_TICKS);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!raw) begin
            cnt_d = '0;
        end else if (tick && cnt_q != LIM) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign held = (cnt_q == LIM);
endmodule

// File: rtl/cell_charge_seq.sv
module cell_charge_seq
    import chg_pkg::*;
#(
    parameter int DG_TICKS  = 375,
    parameter int PRE_TICKS = 1800000,
    parameter int CHG_TICKS = 25200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic in_above_batt,
    input  logic in_above_uvlo,
    input  logic batt_low,
    input  logic batt_below_rch,
    input  logic chg_term,
    input  logic charge_en_n,
    output logic pre_en,
    output logic fast_en,
    output logic fault_sense_en,
    output logic stat_a,
    output logic stat_b,
    output logic power_good
);
    localparam int TMAX = (PRE_TICKS > CHG_TICKS) ? PRE_TICKS : CHG_TICKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PRE_LIM = TW'(PRE_TICKS);
    localparam logic [TW-1:0] CHG_LIM = TW'(CHG_TICKS);
    localparam int NSYNC = 6;

    typedef struct packed {
        chg_state_e    st;
        logic [TW-1:0] cnt;
        logic          fsense;
    } seq_t;

    // synchronized flags: {ce, term, rch, low, ok, gt}
    logic [NSYNC-1:0] raw_a, flag_s;
    logic gt_s, ok_s, low_s, rch_s, term_s, ce_s;

    assign raw_a = {charge_en_n, chg_term, batt_below_rch, batt_low, in_above_uvlo, in_above_batt};

    chg_sync #(.W(NSYNC), .INIT(6'b100000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (raw_a),
        .q_s   (flag_s)
    );

    assign {ce_s, term_s, rch_s, low_s, ok_s, gt_s} = flag_s;

    seq_t cur_q, nxt_d, start_v;

    logic [NUM_FLT-1:0] flt_in, flt_out;

    always_comb begin
        flt_in            = '0;
        flt_in[FLT_SLEEP] = ~gt_s;
        flt_in[FLT_LOWV]  = low_s  && (cur_q.st == ST_FAST);
        flt_in[FLT_TERM]  = term_s && (cur_q.st == ST_FAST);
        flt_in[FLT_RCH]   = rch_s  && (cur_q.st == ST_DONE);
    end

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_flt
        chg_dglitch #(.DG_TICKS(DG_TICKS)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_ms),
            .raw   (flt_in[gi]),
            .held  (flt_out[gi])
        );
    end

    always_comb begin
        start_v.st     = low_s ? ST_PRE : ST_FAST;
        start_v.cnt    = '0;
        start_v.fsense = 1'b0;

        nxt_d = cur_q;
        if (!ok_s || flt_out[FLT_SLEEP]) begin
            nxt_d = '{st: ST_SLEEP, cnt: '0, fsense: 1'b0};
        end else if (ce_s) begin
            nxt_d = '{st: ST_OFF, cnt: '0, fsense: 1'b0};
        end else begin
            case (cur_q.st)
                ST_SLEEP, ST_OFF: nxt_d = start_v;
                ST_PRE: begin
                    if (!low_s) begin
                        nxt_d = '{st: ST_FAST, cnt: '0, fsense: 1'b0};
                    end else if (cur_q.cnt >= PRE_LIM) begin
                        nxt_d = '{st: ST_FAULT, cnt: '0, fsense: rch_s};
                    end else if (tick_ms) begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_FAST: begin
                    if (flt_out[FLT_LOWV]) begin
                        nxt_d = '{st: ST_PRE, cnt: '0, fsense: 1'b0};
                    end else if (flt_out[FLT_TERM]) begin
                        nxt_d = '{st: ST_DONE, cnt: '0, fsense: 1'b0};
                    end else if (cur_q.cnt >= CHG_LIM) begin
                        nxt_d = '{st: ST_FAULT, cnt: '0, fsense: rch_s};
                    end else if (tick_ms) begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (flt_out[FLT_RCH]) begin
                        nxt_d = start_v;
                    end
                end
                ST_FAULT: begin
                    if (cur_q.fsense) begin
                        if (!rch_s) nxt_d.fsense = 1'b0;
                    end else if (rch_s) begin
                        nxt_d = start_v;
                    end
                end
                default: nxt_d = '{st: ST_SLEEP, cnt: '0, fsense: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_SLEEP, cnt: '0, fsense: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign pre_en         = (cur_q.st == ST_PRE);
    assign fast_en        = (cur_q.st == ST_FAST);
    assign fault_sense_en = (cur_q.st == ST_FAULT) && cur_q.fsense;
    assign stat_a         = (cur_q.st == ST_PRE) || (cur_q.st == ST_FAST);
    assign stat_b         = (cur_q.st == ST_PRE) || (cur_q.st == ST_DONE);
    assign power_good     = (cur_q.st != ST_SLEEP);
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ok_s,
    input logic ce_s,
    input logic low_s,
    input logic pre_en,
    input logic fast_en,
    input logic fault_sense_en,
    input logic stat_a,
    input logic stat_b,
    input logic power_good
);
    a_r9_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_en, fast_en, fault_sense_en}));

    a_r9_pre_code: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> (stat_a && stat_b));

    a_r9_fast_code: assert property (@(posedge clk) disable iff (!rst_n)
        fast_en |-> (stat_a && !stat_b));

    a_r12_uvlo_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_s |=> (!pre_en && !fast_en && !fault_sense_en && !power_good));

    a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |=> (!pre_en && !fast_en && !fault_sense_en));

    a_r3_pre_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !low_s) |=> !pre_en);

    a_r8_sense_status: assert property (@(posedge clk) disable iff (!rst_n)
        fault_sense_en |-> (!stat_a && !stat_b && power_good));

    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |-> (!pre_en && !fast_en && !stat_a && !stat_b));
endmodule

bind cell_charge_seq chg_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ok_s           (ok_s),
    .ce_s           (ce_s),
    .low_s          (low_s),
    .pre_en         (pre_en),
    .fast_en        (fast_en),
    .fault_sense_en (fault_sense_en),
    .stat_a         (stat_a),
    .stat_b         (stat_b),
    .power_good     (power_good)
);

// File: tb/cell_charge_seq_tb.sv
module cell_charge_seq_tb;
    localparam int DG  = 4;
    localparam int PRE = 20;
    localparam int CHG = 40;
    localparam int NV  = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_ms = 1'b1;
    logic gt = 1'b0, ok = 1'b0, low = 1'b0, rch = 1'b0, term = 1'b0, ce_n = 1'b1;
    logic pre_en, fast_en, fault_sense_en, stat_a, stat_b, power_good;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    cell_charge_seq #(.DG_TICKS(DG), .PRE_TICKS(PRE), .CHG_TICKS(CHG)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_ms        (tick_ms),
        .in_above_batt  (gt),
        .in_above_uvlo  (ok),
        .batt_low       (low),
        .batt_below_rch (rch),
        .chg_term       (term),
        .charge_en_n    (ce_n),
        .pre_en         (pre_en),
        .fast_en        (fast_en),
        .fault_sense_en (fault_sense_en),
        .stat_a         (stat_a),
        .stat_b         (stat_b),
        .power_good     (power_good)
    );

    // row: {gt,ok,low,rch,term,ce_n}[23:18] wait[17:10] exp{pre,fast,fs,sa,sb,pg}[9:4] req[3:0]
    localparam logic [23:0] VEC [0:NV-1] = '{
        {6'b000001, 8'd6,  6'b000000, 4'd1 },  // R1 sleep
        {6'b111101, 8'd6,  6'b000001, 4'd10},  // R10 disabled
        {6'b111100, 8'd6,  6'b100111, 4'd2 },  // R2 start precharge
        {6'b110100, 8'd6,  6'b010101, 4'd3 },  // R3 immediate fast
        {6'b110010, 8'd3,  6'b010101, 4'd6 },  // R6 not yet
        {6'b110010, 8'd8,  6'b000011, 4'd6 },  // R6 done
        {6'b110100, 8'd3,  6'b000011, 4'd7 },  // R7 not yet
        {6'b110100, 8'd8,  6'b010101, 4'd7 },  // R7 restart
        {6'b111100, 8'd3,  6'b010101, 4'd4 },  // R4 not yet
        {6'b111100, 8'd8,  6'b100111, 4'd4 },  // R4 back to precharge
        {6'b111100, 8'd25, 6'b001001, 4'd5 },  // R5 precharge timeout, R8 sense on
        {6'b111000, 8'd6,  6'b000001, 4'd8 },  // R8 sense off
        {6'b111100, 8'd6,  6'b100111, 4'd8 },  // R8 recovery restart
        {6'b111101, 8'd6,  6'b000001, 4'd10},  // R10 disable
        {6'b110000, 8'd6,  6'b010101, 4'd10},  // R10 re-enable
        {6'b010000, 8'd3,  6'b010101, 4'd11},  // R11 not yet
        {6'b010000, 8'd8,  6'b000000, 4'd11},  // R11 sleep
        {6'b100000, 8'd4,  6'b000000, 4'd12},  // R12 lockout
        {6'b110000, 8'd4,  6'b010101, 4'd12},  // R12 release
        {6'b110000, 8'd45, 6'b000001, 4'd5 },  // R5 charge timeout, no sense
        {6'b110100, 8'd6,  6'b010101, 4'd8 }   // R8 recovery restart
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {pre_en, fast_en, fault_sense_en, stat_a, stat_b, power_good};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1", 6'b000000);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {gt, ok, low, rch, term, ce_n} = VEC[i][23:18];
            step(int'(VEC[i][17:10]));
            check($sformatf("R%0d row %0d", VEC[i][3:0], i), VEC[i][9:4]);
        end

        // R5: timer frozen without tick
        ce_n = 1'b1; low = 1'b1; rch = 1'b1;
        step(6);
        tick_ms = 1'b0; ce_n = 1'b0;
        step(100);
        check("R5 no tick keeps precharge", 6'b100111);
        tick_ms = 1'b1;
        step(25);
        check("R5 timeout after ticks", 6'b001001);

        // R10: enable toggle clears fault
        ce_n = 1'b1;
        step(6);
        check("R10 disabled from fault", 6'b000001);
        ce_n = 1'b0;
        step(6);
        check("R10 falling edge restarts", 6'b100111);

        // R12: lockout acts without deglitch
        low = 1'b0;
        step(6);
        check("R12 fast before lockout", 6'b010101);
        tick_ms = 1'b0; ok = 1'b0;
        step(3);
        check("R12 lockout immediate", 6'b000000);
        ok = 1'b1; tick_ms = 1'b1;
        step(6);
        check("R11 leaves sleep at once", 6'b010101);

        // R1: reset mid-run
        rst_n = 1'b0;
        step(1);
        check("R1 reset mid-run", 6'b000000);
        rst_n = 1'b1;
        step(6);
        check("R2 start after reset", 6'b010101);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule